// File: doc/BRIEF.md
# Fast-Lock Bandwidth Timer

After a channel change, a fractional-N synthesizer loop can settle faster if the charge pump runs at raised current for a short time. This block controls that time. A new-channel pulse arrives when the divider word is written. If the fast-lock enable bit is set at that moment, the block loads the 12-bit timer value and opens a wide-bandwidth window. While the window is open, the charge-pump multiplier select reads 16 times the minimum current and the wide-bandwidth indicator is high. Once the programmed number of PFD cycles has passed, both return to normal.

The count advances only on cycles where the PFD-rate clock enable is high. The timer value comes from the R-register field that is written with load control set. A later divider write restarts the window from the full value. The synthesizer counter-reset bit drops the block back to normal current at once.

Top module: `flt_top`

## Requirements
- R1: After reset, `wideBw` is 0 and `cpMultSel` is 1.
- R2: When `newChan` is high with `fastLockEn`=1, `timerVal`≠0 and `cntReset`=0, `wideBw` is 1 from the next clock edge.
- R3: An opened window lasts exactly `timerVal` cycles with `pfdTick`=1. `wideBw` falls at the clock edge that takes the last of those ticks. A value of 1 gives a single-tick window, and the maximum of 4095 gives 4095 ticks.
- R4: Clock cycles with `pfdTick`=0 neither shorten nor close an open window.
- R5: `newChan` with `fastLockEn`=0 opens no window, and it closes a window that is already open at the next edge.
- R6: `newChan` with `timerVal`=0 opens no window, and it closes an open window at the next edge.
- R7: `newChan` during an open window restarts the count from the full new `timerVal`. A `pfdTick` in the same cycle as `newChan` is not counted.
- R8: `cntReset`=1 makes `wideBw` 0 at the next edge and takes priority over a `newChan` in the same cycle.
- R9: `cpMultSel` is 16 (5-bit value 5'd16) whenever `wideBw` is 1, and 1 (5'd1) whenever `wideBw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pfdTick | input | 1 | PFD-rate clock enable, high for one cycle per PFD period |
| newChan | input | 1 | One-cycle pulse when the divider word is written |
| fastLockEn | input | 1 | Fast-lock enable bit from the divider word |
| timerVal | input | 12 | Fast-lock window length in PFD cycles |
| cntReset | input | 1 | Synthesizer counter reset |
| wideBw | output | 1 | High while the wide-bandwidth window is open |
| cpMultSel | output | 5 | Charge-pump current multiplier: 16 in the window, 1 otherwise |

## Verification
A remaining count or state bit that is wrong shows at the ports as a window edge in the wrong place. `wideBw` and `cpMultSel` would flip one or more PFD ticks early or late, or a window would reopen without cause. The bench compares both outputs after every clock edge against a cycle-exact model. A wrong state is therefore reported within one cycle of the point where its effect reaches the outputs. Windows of 1, 3, 5 and 4095 ticks, gaps in the tick stream and same-cycle collisions place the expiry edge in several different positions.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef struct packed {
    logic load;   // take the programmed length
    logic dec;    // one PFD period elapsed
    logic clear;  // drop to zero
  } fltStrobe_t;
endpackage

// File: rtl/flt_ctrl.sv
module flt_ctrl
  import flt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       newChan,
  input  logic       pfdTick,
  input  logic       fastLockEn,
  input  logic       valIsZero,
  input  logic       cntReset,
  input  logic       lastCount,
  output fltStrobe_t strobe,
  output logic       active
);
  logic activeNext;

  always_comb begin
    strobe     = '0;
    activeNext = active;
    if (cntReset) begin
      strobe.clear = 1'b1;
      activeNext   = 1'b0;
    end else if (newChan) begin
      if (fastLockEn && !valIsZero) begin
        strobe.load = 1'b1;
        activeNext  = 1'b1;
      end else begin
        strobe.clear = 1'b1;
        activeNext   = 1'b0;
      end
    end else if (active && pfdTick) begin
      strobe.dec = 1'b1;
      if (lastCount) activeNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= activeNext;
  end

  // R8: counter reset wins over everything
  a_r8_reset_closes: assert property (@(posedge clk) disable iff (!rstN)
    cntReset |=> !active);
  // R2: enabled write with nonzero length opens the window
  a_r2_open: assert property (@(posedge clk) disable iff (!rstN)
    (newChan && fastLockEn && !valIsZero && !cntReset) |=> active);
  // R5: write with fast-lock disabled leaves no window
  a_r5_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (newChan && !fastLockEn) |=> !active);
  // R6: zero length leaves no window
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (newChan && valIsZero) |=> !active);
endmodule

// File: rtl/flt_dp.sv
module flt_dp
  import flt_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  fltStrobe_t    strobe,
  input  logic [TW-1:0] timerVal,
  output logic          valIsZero,
  output logic          lastCount
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             remain <= '0;
    else if (strobe.clear) remain <= '0;
    else if (strobe.load)  remain <= timerVal;
    else if (strobe.dec)   remain <= remain - ONE;
  end

  assign valIsZero = (timerVal == '0);
  assign lastCount = (remain == ONE);

  // R3: a tick is never taken from an empty count
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> (remain != '0));
  // R7: a restart reloads the full programmed length
  a_r7_full_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (remain == $past(timerVal)));
  // R4: without a strobe the count holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(remain));
endmodule

// File: rtl/flt_top.sv
module flt_top
  import flt_pkg::*;
#(
  parameter int TW      = 12,
  parameter int MW      = 5,
  parameter int HI_MULT = 16,
  parameter int LO_MULT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pfdTick,
  input  logic          newChan,
  input  logic          fastLockEn,
  input  logic [TW-1:0] timerVal,
  input  logic          cntReset,
  output logic          wideBw,
  output logic [MW-1:0] cpMultSel
);
  localparam logic [MW-1:0] MULT_HI = MW'(HI_MULT);
  localparam logic [MW-1:0] MULT_LO = MW'(LO_MULT);

  fltStrobe_t strobe;
  logic       valIsZero;
  logic       lastCount;
  logic       active;

  flt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .newChan   (newChan),
    .pfdTick   (pfdTick),
    .fastLockEn(fastLockEn),
    .valIsZero (valIsZero),
    .cntReset  (cntReset),
    .lastCount (lastCount),
    .strobe    (strobe),
    .active    (active)
  );

  flt_dp #(.TW(TW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .timerVal (timerVal),
    .valIsZero(valIsZero),
    .lastCount(lastCount)
  );

  assign wideBw    = active;
  assign cpMultSel = active ? MULT_HI : MULT_LO;

  // R9: multiplier follows the window at every edge
  a_r9_mult_tracks: assert property (@(posedge clk) disable iff (!rstN)
    wideBw ? (cpMultSel == MULT_HI) : (cpMultSel == MULT_LO));
endmodule

// File: tb/sim_flt_top.sv
module sim_flt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pfdTick = 1'b0;
  logic        newChan = 1'b0;
  logic        fastLockEn = 1'b0;
  logic [11:0] timerVal = '0;
  logic        cntReset = 1'b0;
  logic        wideBw;
  logic [4:0]  cpMultSel;

  int errors = 0;
  int checks = 0;
  int expRem = 0;
  bit done = 1'b0;

  typedef struct {
    bit    wide;
    string tag;
  } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  flt_top u0 (
    .clk(clk), .rstN(rstN), .pfdTick(pfdTick), .newChan(newChan),
    .fastLockEn(fastLockEn), .timerVal(timerVal), .cntReset(cntReset),
    .wideBw(wideBw), .cpMultSel(cpMultSel)
  );

  // driver: apply one cycle of stimulus, predict the state after the edge
  task automatic step(input bit nc, input bit tk, input bit en,
                      input int val, input bit rs, input string tag);
    item_t it;
    @(negedge clk);
    newChan = nc; pfdTick = tk; fastLockEn = en;
    timerVal = 12'(val); cntReset = rs;
    if (rs)                 expRem = 0;
    else if (nc)            expRem = (en && val != 0) ? val : 0;
    else if (expRem > 0 && tk) expRem = expRem - 1;
    it.wide = (expRem > 0);
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n, input bit tk, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tk, 1'b0, 0, 1'b0, tag);
  endtask

  // monitor: compare after every edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      logic [4:0] expM;
      it = sbq.pop_front();
      expM = it.wide ? 5'd16 : 5'd1;
      checks++;
      if (wideBw !== it.wide || cpMultSel !== expM) begin
        errors++;
        $display("FAIL %s (R9): wideBw=%0b cpMultSel=%0d expected wideBw=%0b cpMultSel=%0d",
                 it.tag, wideBw, cpMultSel, it.wide, expM);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (wideBw !== 1'b0 || cpMultSel !== 5'd1) begin
      errors++;
      $display("FAIL R1 reset: wideBw=%0b cpMultSel=%0d expected 0/1", wideBw, cpMultSel);
    end
    rstN = 1'b1;

    // R2/R3: five-tick window, ticks every cycle
    step(1, 0, 1, 5, 0, "R2 open");
    idle(7, 1'b1, "R3 expiry of 5");
    // R4: sparse ticks
    step(1, 0, 1, 3, 0, "R2 open 3");
    for (int i = 0; i < 4; i++) begin
      idle(3, 1'b0, "R4 no tick hold");
      idle(1, 1'b1, "R4 sparse tick");
    end
    // R3: single tick window
    step(1, 0, 1, 1, 0, "R3 len 1");
    idle(2, 1'b0, "R3 len 1 wait");
    idle(2, 1'b1, "R3 len 1 tick");
    // R7: retrigger mid-window, tick in same cycle ignored
    step(1, 0, 1, 4, 0, "R7 first");
    idle(2, 1'b1, "R7 partial");
    step(1, 1, 1, 4, 0, "R7 retrigger with tick");
    idle(5, 1'b1, "R7 full restart");
    // R5: disabled write
    step(1, 1, 0, 6, 0, "R5 disabled");
    idle(2, 1'b1, "R5 no window");
    step(1, 0, 1, 6, 0, "R5 open");
    idle(1, 1'b1, "R5 in window");
    step(1, 0, 0, 6, 0, "R5 close by disabled");
    idle(2, 1'b1, "R5 stays closed");
    // R6: zero length
    step(1, 0, 1, 0, 0, "R6 zero");
    idle(2, 1'b1, "R6 no window");
    step(1, 0, 1, 6, 0, "R6 open");
    step(1, 0, 1, 0, 0, "R6 close by zero");
    idle(1, 1'b1, "R6 stays closed");
    // R8: counter reset in window and against a write
    step(1, 0, 1, 9, 0, "R8 open");
    idle(2, 1'b0, "R8 in window");
    step(0, 1, 0, 0, 1, "R8 reset closes");
    step(1, 0, 1, 9, 1, "R8 reset beats write");
    idle(2, 1'b1, "R8 stays closed");
    // R3: maximum length
    step(1, 0, 1, 4095, 0, "R3 max open");
    idle(4097, 1'b1, "R3 max expiry");
    idle(2, 1'b0, "R1 drain");
    @(posedge clk); #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule